// File: doc/BRIEF.md
# Interleaved Group Issue Scheduler

This block decides, on every clock, which of the fragment groups resident on one shared SIMD core gets to issue. A group is loaded with a start pulse and becomes runnable. When the issuing group reaches a long-latency operation such as a texture fetch, the core raises that group's stall request. The group then leaves the runnable pool until its data-return pulse arrives, and meanwhile other groups keep the ALUs busy. A done pulse on an issuing group retires it until it is started again.

Picks rotate round-robin, starting just after the group that issued most recently. In the dual-issue build, two different groups are chosen in the same clock. The second pick continues the rotation from the first one. Each group runs a small state machine with these states and transitions:

- IDLE --start--> RUN
- RUN --issue with stall request--> STALL
- RUN --issue with done--> DONE
- STALL --data return--> RUN
- DONE --start--> RUN

Top module: `grp_issue_sched`

## Requirements
- R1: After reset every group is IDLE, every sel_valid bit is 0 and every sel_id field reads 0.
- R2: A start pulse for an IDLE or DONE group makes it runnable from the next clock. A start pulse for a group in RUN or STALL is ignored.
- R3: Only groups in RUN are reported. When no group is in RUN, all sel_valid bits are 0 and all sel_id fields are 0.
- R4: Slot 0 picks the first runnable group in ascending circular order, beginning just after the most recently issued group. After reset the search begins at group 0. The most recently issued group is slot 1's pick when slot 1 is valid, and slot 0's pick otherwise.
- R5: A stall request on a group issued this clock moves it to STALL from the next clock, and it is not reported again until its data returns. A stall request on a group that is not issuing is ignored.
- R6: Data return on a STALL group makes it runnable, and selectable, on the next clock. Data return on a group in any other state is ignored.
- R7: A done pulse on a group issued this clock moves it to DONE, and it is never reported again until it is restarted. If done and a stall request arrive together, done takes priority, so a later data return does not revive the group. A done pulse on a group that is not issuing is ignored.
- R8: In the dual-issue build, slot 1 (sel_id bits [2*IDW-1:IDW], sel_valid bit 1) carries the next runnable group after slot 0's pick in circular order. Slot 1 is never the same group as slot 0, and it is valid only when at least two groups are runnable. Slot 0 occupies sel_id bits [IDW-1:0] and sel_valid bit 0.
- R9: A group that stays in RUN is reported within NUM_GRP clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| grp_start | input | NUM_GRP | Per-group load pulse |
| grp_stall_req | input | NUM_GRP | Per-group long-latency stall request, applied to issuing groups |
| grp_data_ret | input | NUM_GRP | Per-group data-return pulse |
| grp_done | input | NUM_GRP | Per-group program-end pulse, applied to issuing groups |
| sel_id | output | ISSUE_W*IDW | Chosen group IDs, slot k at bits [k*IDW +: IDW] |
| sel_valid | output | ISSUE_W | Per-slot valid flag |

## Verification
A group stuck in the wrong state shows up at the ports within one clock. A stalled or retired group left in RUN appears on sel_id with sel_valid set. A returned group that never leaves STALL is skipped, and the rotation order visibly changes. A wrong round-robin pointer or second-slot search shows up in the next clock's ID pair, so every directed step compares the exact pair of IDs. A random phase tracks the state of each group from the pulses it drives and confirms that no stalled group issues and that no runnable group waits longer than the bound.

// File: rtl/grp_sched_pkg.sv
package grp_sched_pkg;
    typedef enum logic [1:0] {
        GS_IDLE  = 2'd0,
        GS_RUN   = 2'd1,
        GS_STALL = 2'd2,
        GS_DONE  = 2'd3
    } grp_st_e;
endpackage

// File: rtl/grp_state.sv
module grp_state
    import grp_sched_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    start,
    input  logic    issued,
    input  logic    stall_req,
    input  logic    data_ret,
    input  logic    done,
    output grp_st_e st,
    output logic    runnable,
    output logic    stalled
);
    grp_st_e st_nxt;

    always_comb begin
        st_nxt = st;
        unique case (st)
            GS_IDLE:  if (start) st_nxt = GS_RUN;
            GS_RUN: begin
                // retiring outranks stalling
                if (issued && done)           st_nxt = GS_DONE;
                else if (issued && stall_req) st_nxt = GS_STALL;
            end
            GS_STALL: if (data_ret) st_nxt = GS_RUN;
            GS_DONE:  if (start) st_nxt = GS_RUN;
            default:  st_nxt = GS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st <= GS_IDLE;
        else        st <= st_nxt;
    end

    always_comb begin
        runnable = (st == GS_RUN);
        stalled  = (st == GS_STALL);
    end
endmodule

// File: rtl/rr_pick.sv
module rr_pick #(
    parameter int N   = 8,
    parameter int IDW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]   mask,
    input  logic [IDW-1:0] base,
    output logic           found,
    output logic [IDW-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = 0; i < N; i++) begin
            int c;
            c = (int'(base) + i) % N;
            if (!found && mask[c]) begin
                found = 1'b1;
                idx   = c[IDW-1:0];
            end
        end
    end
endmodule

// File: rtl/grp_issue_sched.sv
module grp_issue_sched
    import grp_sched_pkg::*;
#(
    parameter int NUM_GRP     = 8,
    parameter bit DUAL_ISSUE  = 1'b0,
    localparam int IDW        = (NUM_GRP > 1) ? $clog2(NUM_GRP) : 1,
    localparam int ISSUE_W    = DUAL_ISSUE ? 2 : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM_GRP-1:0]     grp_start,
    input  logic [NUM_GRP-1:0]     grp_stall_req,
    input  logic [NUM_GRP-1:0]     grp_data_ret,
    input  logic [NUM_GRP-1:0]     grp_done,
    output logic [ISSUE_W*IDW-1:0] sel_id,
    output logic [ISSUE_W-1:0]     sel_valid
);
    localparam logic [IDW-1:0] LAST_ID = IDW'(NUM_GRP - 1);

    logic [NUM_GRP-1:0] run_vec;
    logic [NUM_GRP-1:0] stall_vec;
    logic [NUM_GRP-1:0] issued;
    logic [IDW-1:0]     last_id;
    logic [IDW-1:0]     base0;
    logic               p0_v, p1_v;
    logic [IDW-1:0]     p0_id, p1_id;

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
        grp_sched_pkg::grp_st_e st_g;
        grp_state u_st (
            .clk       (clk),
            .rst_n     (rst_n),
            .start     (grp_start[g]),
            .issued    (issued[g]),
            .stall_req (grp_stall_req[g]),
            .data_ret  (grp_data_ret[g]),
            .done      (grp_done[g]),
            .st        (st_g),
            .runnable  (run_vec[g]),
            .stalled   (stall_vec[g])
        );
        assign issued[g] = (p0_v && p0_id == IDW'(g)) || (p1_v && p1_id == IDW'(g));
    end

    assign base0 = (last_id == LAST_ID) ? '0 : last_id + 1'b1;

    rr_pick #(.N(NUM_GRP), .IDW(IDW)) u_pick0 (
        .mask  (run_vec),
        .base  (base0),
        .found (p0_v),
        .idx   (p0_id)
    );

    if (DUAL_ISSUE) begin : g_dual
        logic [NUM_GRP-1:0] mask1;
        logic [IDW-1:0]     base1;
        always_comb begin
            mask1        = run_vec;
            mask1[p0_id] = 1'b0;
        end
        assign base1 = (p0_id == LAST_ID) ? '0 : p0_id + 1'b1;
        rr_pick #(.N(NUM_GRP), .IDW(IDW)) u_pick1 (
            .mask  (mask1),
            .base  (base1),
            .found (p1_v),
            .idx   (p1_id)
        );
    end else begin : g_single
        assign p1_v  = 1'b0;
        assign p1_id = '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)    last_id <= LAST_ID;
        else if (p1_v) last_id <= p1_id;
        else if (p0_v) last_id <= p0_id;
    end

    always_comb begin
        sel_id       = '0;
        sel_valid    = '0;
        sel_valid[0] = p0_v;
        sel_id[0 +: IDW] = p0_v ? p0_id : '0;
        if (ISSUE_W > 1) begin
            sel_valid[ISSUE_W-1] = p1_v;
            sel_id[(ISSUE_W-1)*IDW +: IDW] = p1_v ? p1_id : '0;
        end
    end
endmodule

// File: rtl/grp_issue_chk.sv
module grp_issue_chk #(
    parameter int NUM_GRP = 8,
    parameter int IDW     = 3,
    parameter int ISSUE_W = 1
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [NUM_GRP-1:0]     run_vec,
    input logic [NUM_GRP-1:0]     stall_vec,
    input logic [NUM_GRP-1:0]     grp_data_ret,
    input logic [ISSUE_W*IDW-1:0] sel_id,
    input logic [ISSUE_W-1:0]     sel_valid
);
    localparam int CW = $clog2(NUM_GRP + 2) + 1;

    a_r3_none_runnable: assert property (@(posedge clk) disable iff (!rst_n)
        (run_vec == '0) |-> (sel_valid == '0));

    for (genvar k = 0; k < ISSUE_W; k++) begin : g_slot
        a_r3_sel_is_runnable: assert property (@(posedge clk) disable iff (!rst_n)
            sel_valid[k] |-> run_vec[sel_id[k*IDW +: IDW]]);
    end

    if (ISSUE_W > 1) begin : g_dual
        a_r8_distinct: assert property (@(posedge clk) disable iff (!rst_n)
            (&sel_valid) |-> (sel_id[IDW-1:0] != sel_id[2*IDW-1:IDW]));
        a_r8_second_needs_first: assert property (@(posedge clk) disable iff (!rst_n)
            sel_valid[1] |-> sel_valid[0]);
    end

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
        logic          iss;
        logic [CW-1:0] wait_cnt;
        always_comb begin
            iss = 1'b0;
            for (int k = 0; k < ISSUE_W; k++)
                if (sel_valid[k] && sel_id[k*IDW +: IDW] == IDW'(g)) iss = 1'b1;
        end
        always_ff @(posedge clk) begin
            if (!rst_n || !run_vec[g] || iss) wait_cnt <= '0;
            else if (wait_cnt != '1)           wait_cnt <= wait_cnt + 1'b1;
        end

        a_r6_return_wakes: assert property (@(posedge clk) disable iff (!rst_n)
            (stall_vec[g] && grp_data_ret[g]) |=> run_vec[g]);
        a_r5_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
            (stall_vec[g] && !grp_data_ret[g]) |=> stall_vec[g]);
        a_r9_no_starve: assert property (@(posedge clk) disable iff (!rst_n)
            wait_cnt < CW'(NUM_GRP));
    end
endmodule

bind grp_issue_sched grp_issue_chk #(
    .NUM_GRP (NUM_GRP),
    .IDW     (IDW),
    .ISSUE_W (ISSUE_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .run_vec      (run_vec),
    .stall_vec    (stall_vec),
    .grp_data_ret (grp_data_ret),
    .sel_id       (sel_id),
    .sel_valid    (sel_valid)
);

// File: tb/tb_grp_issue_sched.sv
`timescale 1ns/1ps
module tb_grp_issue_sched;
    localparam int N = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] st_i = '0, sr_i = '0, dr_i = '0, dn_i = '0;
    logic [3:0]   sel_id;
    logic [1:0]   sel_valid;
    int           n_run = 0, n_fail = 0;

    always #10 clk = ~clk;

    grp_issue_sched #(.NUM_GRP(N), .DUAL_ISSUE(1'b1)) dut (
        .clk (clk), .rst_n (rst_n),
        .grp_start (st_i), .grp_stall_req (sr_i),
        .grp_data_ret (dr_i), .grp_done (dn_i),
        .sel_id (sel_id), .sel_valid (sel_valid)
    );

    task automatic tick(input logic [N-1:0] s, sr, dr, dn);
        st_i = s; sr_i = sr; dr_i = dr; dn_i = dn;
        @(posedge clk); #1;
        st_i = '0; sr_i = '0; dr_i = '0; dn_i = '0;
        @(negedge clk);
    endtask

    task automatic expect_sel(input string req, input logic [1:0] ev,
                              input logic [1:0] e0, input logic [1:0] e1);
        n_run++;
        if (sel_valid !== ev || sel_id[1:0] !== e0 || sel_id[3:2] !== e1) begin
            n_fail++;
            $display("FAIL %s: valid=%b id0=%0d id1=%0d expected valid=%b id0=%0d id1=%0d",
                     req, sel_valid, sel_id[1:0], sel_id[3:2], ev, e0, e1);
        end
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        expect_sel("R1 reset idle", 2'b00, 0, 0);
    endtask

    task automatic t_rotate;
        tick(4'b0111, 0, 0, 0);
        expect_sel("R2 start + R4 first pick", 2'b11, 0, 1);
        tick(0, 0, 0, 0);
        expect_sel("R4 rotate", 2'b11, 2, 0);
        tick(0, 0, 0, 0);
        expect_sel("R8 second follows first", 2'b11, 1, 2);
    endtask

    task automatic t_stall_return;
        // issuing 1,2 stall; group 0 not issuing so its request is ignored
        tick(0, 4'b0111, 0, 0);
        expect_sel("R5 stall issued groups", 2'b01, 0, 0);
        tick(0, 0, 0, 0);
        expect_sel("R8 single runnable", 2'b01, 0, 0);
        tick(0, 0, 4'b1011, 0);
        expect_sel("R6 return wakes next clock", 2'b11, 1, 0);
    endtask

    task automatic t_done;
        tick(0, 4'b0001, 0, 4'b0001);
        expect_sel("R7 done retires", 2'b01, 1, 0);
        tick(0, 0, 4'b0001, 0);
        expect_sel("R7 done over stall, return ignored", 2'b01, 1, 0);
        tick(0, 0, 0, 4'b0010);
        expect_sel("R3 none runnable", 2'b00, 0, 0);
        tick(4'b0100, 0, 0, 0);
        expect_sel("R2 start on stalled ignored", 2'b00, 0, 0);
        tick(4'b1001, 0, 4'b0100, 0);
        expect_sel("R2 restart + R4 after last", 2'b11, 2, 3);
        tick(0, 0, 0, 0);
        expect_sel("R4 wrap", 2'b11, 0, 2);
        tick(0, 0, 0, 0);
        expect_sel("R4 wrap again", 2'b11, 3, 0);
    endtask

    task automatic t_random;
        int st[N];
        int wt[N];
        tick(4'b0010, 0, 0, 0);
        for (int g = 0; g < N; g++) begin st[g] = 1; wt[g] = 0; end
        for (int cyc = 0; cyc < 300; cyc++) begin
            logic [N-1:0] sr, dr, iss;
            int nr;
            bit bad;
            nr = 0; bad = 0; iss = '0;
            for (int g = 0; g < N; g++) if (st[g] == 1) nr++;
            if (sel_valid[0]) iss[sel_id[1:0]] = 1'b1;
            if (sel_valid[1]) iss[sel_id[3:2]] = 1'b1;
            if (sel_valid[0] && st[sel_id[1:0]] != 1) bad = 1;
            if (sel_valid[1] && st[sel_id[3:2]] != 1) bad = 1;
            if (&sel_valid && sel_id[1:0] == sel_id[3:2]) bad = 1;
            if (32'(sel_valid[0]) + 32'(sel_valid[1]) != ((nr > 2) ? 2 : nr)) bad = 1;
            n_run++;
            if (bad) begin
                n_fail++;
                $display("FAIL R3/R8 random cyc %0d: valid=%b id0=%0d id1=%0d expected %0d runnable only",
                         cyc, sel_valid, sel_id[1:0], sel_id[3:2], nr);
            end
            for (int g = 0; g < N; g++) begin
                if (st[g] == 1 && !iss[g]) wt[g]++; else wt[g] = 0;
                if (wt[g] >= N) begin
                    n_run++; n_fail++;
                    $display("FAIL R9 group %0d waited %0d expected < %0d", g, wt[g], N);
                    wt[g] = 0;
                end
            end
            sr = '0; dr = '0;
            for (int g = 0; g < N; g++) begin
                if (iss[g] && ($urandom % 3 == 0)) sr[g] = 1'b1;
                if (st[g] == 2 && ($urandom % 4 == 0)) dr[g] = 1'b1;
            end
            for (int g = 0; g < N; g++) begin
                if (iss[g] && sr[g]) st[g] = 2;
                else if (st[g] == 2 && dr[g]) st[g] = 1;
            end
            tick(0, sr, dr, 0);
        end
    endtask

    initial begin
        @(negedge clk);
        fork
            begin
                t_reset();
                t_rotate();
                t_stall_return();
                t_done();
                t_random();
            end
            begin
                repeat (20000) @(posedge clk);
                n_run++; n_fail++;
                $display("FAIL watchdog: run did not finish, expected completion");
            end
        join_any
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule